// File: doc/BRIEF.md
# Ethernet Receive Address and Type Filter

This block looks at the first fourteen bytes of each received Ethernet frame and decides whether the frame should be kept. Bytes arrive one per transfer on a valid/ready stream that begins right after the start-of-frame delimiter. A start-of-frame strobe marks the first destination octet. The block keeps the six destination-address octets and the two length/type octets. It compares them against four programmable address slots and four programmable type slots. The result is posted one cycle after the fourteenth header byte. It consists of an accept flag, a per-slot address hit vector, a type hit flag with the 2-bit number of the winning type slot, and multicast and broadcast indications.

Software programs the slots through a simple write port. An address slot is armed when its upper half is written and disarmed when its lower half is written. A type slot carries its own enable bit. When a frame opens, the block copies the whole configuration, so a write that lands while a frame is in flight only applies to later frames. The stream never applies back-pressure: `rx_ready` is held high, and the upstream source may present a byte on any cycle and drop `rx_valid` between bytes at will.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: `rx_ready` is always 1. A byte is taken on every clock edge where `rx_valid` is 1, and bytes with `rx_valid` at 0 are ignored. A taken byte with `rx_sof` at 1 is header byte 0. Bytes taken before the first start of frame, and bytes after header byte 13, do not produce a result.
- R2: Write map, selected by `reg_addr[3:2]` with the slot number in `reg_addr[1:0]`: 0 selects an address-slot lower word, 1 an address-slot upper word (bits [15:0] used), and 2 a type slot.
- R3: Destination octet k (k=0 first on the wire) is compared with bits [8k+7:8k] of the 48-bit value {upper[15:0], lower[31:0]}. For example, 21:43:65:87:A9:CB matches lower 0x87654321 and upper 0x0000CBA9.
- R4: Writing an address slot's upper word arms the slot. Writing its lower word, or applying reset, disarms it.
- R5: `addr_hit[i]` is 1 when slot i is armed and the received destination equals the slot value.
- R6: A type slot takes part only when bit 31 is 1. Its bits [15:0] are compared with {header byte 12, header byte 13}, and bits [30:16] are ignored.
- R7: When several type slots match, `type_idx` gives the lowest-numbered one. `type_hit` qualifies the index, and `type_idx` is 0 when no type slot matches.
- R8: `accept` is the OR of all address hits and the type hit.
- R9: `res_valid` pulses for one cycle on the cycle after header byte 13 is taken, and the result outputs update at that same point. They then hold until the next start-of-frame byte is taken, which clears them all to 0.
- R10: `mcast` is bit 0 of destination octet 0. `bcast` is 1 when all 48 destination bits are 1.
- R11: A slot write taken after a frame's start-of-frame byte does not change that frame's result, but it does apply to the next frame.
- R12: After reset all outputs are 0 except `rx_ready`, all address slots are disarmed and all type slots are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Always 1; the filter never stalls |
| rx_sof | input | 1 | Byte is the first destination octet |
| rx_data | input | 8 | Received byte |
| reg_we | input | 1 | Slot write strobe |
| reg_addr | input | 4 | Slot write address |
| reg_wdata | input | 32 | Slot write data |
| res_valid | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted |
| addr_hit | output | 4 | Per-slot destination address hit |
| type_hit | output | 1 | Some enabled type slot matched |
| type_idx | output | 2 | Lowest matching type slot |
| mcast | output | 1 | Group bit of destination set |
| bcast | output | 1 | Destination is all ones |

## Verification
The bench builds the filter with its default four address slots and four type slots. With these values every slot number and all four codes of the 2-bit type index can be reached. Directed frames make several type slots match at once, so the lowest-index rule is tested with real contention. Random frames draw their destination and type either from the programmed slots or at random, insert idle gaps between bytes, and rewrite slots both between frames and in mid-frame.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;
  localparam int ADDR_SLOTS = 4;
  localparam int TYPE_SLOTS = 4;
  localparam int HDR_LEN    = 14;
  localparam int DA_LEN     = 6;
  localparam int TYPE_POS   = 12;
  localparam int REG_AW     = 4;
  localparam int DW         = 32;

  typedef enum logic [1:0] {
    GRP_ADDR_LO = 2'd0,
    GRP_ADDR_HI = 2'd1,
    GRP_TYPE    = 2'd2,
    GRP_NONE    = 2'd3
  } reg_grp_e;

  typedef struct packed {
    logic        armed;
    logic [15:0] hi;
    logic [31:0] lo;
  } addr_slot_t;

  typedef struct packed {
    logic        en;
    logic [15:0] id;
  } type_slot_t;
endpackage

// File: rtl/eth_filt_cfg.sv
module eth_filt_cfg
  import eth_filt_pkg::*;
#(
  parameter int NA = ADDR_SLOTS,
  parameter int NT = TYPE_SLOTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     snap,
  output addr_slot_t [NA-1:0]      frm_addr,
  output type_slot_t [NT-1:0]      frm_type,
  output logic [NA-1:0]            live_armed
);
  localparam int IDXW = 2;

  reg_grp_e        grp;
  logic [IDXW-1:0] idx;
  addr_slot_t      live_a [NA];
  type_slot_t      live_t [NT];

  assign grp = reg_grp_e'(wr_addr[REG_AW-1 -: 2]);
  assign idx = wr_addr[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) live_a[i] <= '0;
      for (int j = 0; j < NT; j++) live_t[j] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NA; i++) begin
        if (idx == IDXW'(i) && grp == GRP_ADDR_LO) begin
          live_a[i].lo    <= wr_data;
          live_a[i].armed <= 1'b0;
        end else if (idx == IDXW'(i) && grp == GRP_ADDR_HI) begin
          live_a[i].hi    <= wr_data[15:0];
          live_a[i].armed <= 1'b1;
        end
      end
      for (int j = 0; j < NT; j++) begin
        if (idx == IDXW'(j) && grp == GRP_TYPE) begin
          live_t[j].en <= wr_data[DW-1];
          live_t[j].id <= wr_data[15:0];
        end
      end
    end
  end

  // Per-frame copy taken when a frame opens.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_addr <= '0;
      frm_type <= '0;
    end else if (snap) begin
      for (int i = 0; i < NA; i++) frm_addr[i] <= live_a[i];
      for (int j = 0; j < NT; j++) frm_type[j] <= live_t[j];
    end
  end

  for (genvar g = 0; g < NA; g++) begin : g_arm
    assign live_armed[g] = live_a[g].armed;
  end
endmodule

// File: rtl/eth_filt_hdr.sv
module eth_filt_hdr
  import eth_filt_pkg::*;
#(
  parameter int HLEN = HDR_LEN,
  parameter int DLEN = DA_LEN,
  parameter int TPOS = TYPE_POS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sof,
  input  logic [7:0]          in_data,
  output logic [8*DLEN-1:0]   da,
  output logic [7:0]          type_hi,
  output logic                last_byte,
  output logic                sof_take
);
  localparam int CW = $clog2(HLEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] pos;
  logic          take;

  assign pos       = in_sof ? '0 : cnt;
  assign take      = in_valid && (in_sof || cnt < CW'(HLEN));
  assign last_byte = take && (pos == CW'(HLEN - 1));
  assign sof_take  = in_valid && in_sof;

  // cnt == HLEN means idle: no frame open or header complete.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= CW'(HLEN);
    else if (take) cnt <= pos + 1'b1;
  end

  for (genvar k = 0; k < DLEN; k++) begin : g_oct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           da[8*k +: 8] <= '0;
      else if (take && pos == CW'(k))       da[8*k +: 8] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              type_hi <= '0;
    else if (take && pos == CW'(TPOS))       type_hi <= in_data;
  end
endmodule

// File: rtl/eth_filt_match.sv
module eth_filt_match
  import eth_filt_pkg::*;
#(
  parameter int NA = ADDR_SLOTS,
  parameter int NT = TYPE_SLOTS,
  parameter int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  addr_slot_t [NA-1:0] frm_addr,
  input  type_slot_t [NT-1:0] frm_type,
  input  logic [47:0]         da,
  input  logic [15:0]         ftype,
  output logic [NA-1:0]       a_hit,
  output logic                t_hit,
  output logic [IW-1:0]       t_idx,
  output logic                is_mc,
  output logic                is_bc
);
  logic [NT-1:0] t_vec;

  for (genvar i = 0; i < NA; i++) begin : g_a
    assign a_hit[i] = frm_addr[i].armed && (da == {frm_addr[i].hi, frm_addr[i].lo});
  end

  for (genvar j = 0; j < NT; j++) begin : g_t
    assign t_vec[j] = frm_type[j].en && (frm_type[j].id == ftype);
  end

  // Scan high to low so the lowest matching slot is written last.
  always_comb begin
    t_idx = '0;
    for (int j = NT - 1; j >= 0; j--) begin
      if (t_vec[j]) t_idx = IW'(j);
    end
  end

  assign t_hit = |t_vec;
  assign is_mc = da[0];
  assign is_bc = &da;
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eth_filt_pkg::*;
#(
  parameter int NA = ADDR_SLOTS,
  parameter int NT = TYPE_SLOTS,
  parameter int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic              res_valid,
  output logic              accept,
  output logic [NA-1:0]     addr_hit,
  output logic              type_hit,
  output logic [IW-1:0]     type_idx,
  output logic              mcast,
  output logic              bcast
);
  addr_slot_t [NA-1:0] frm_addr;
  type_slot_t [NT-1:0] frm_type;
  logic [NA-1:0]       live_armed;
  logic [47:0]         da;
  logic [7:0]          type_hi;
  logic                last_byte;
  logic                sof_take;
  logic [NA-1:0]       m_ahit;
  logic                m_thit;
  logic [IW-1:0]       m_tidx;
  logic                m_mc;
  logic                m_bc;

  assign rx_ready = 1'b1;

  eth_filt_cfg #(.NA(NA), .NT(NT)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .snap(sof_take),
    .frm_addr(frm_addr), .frm_type(frm_type), .live_armed(live_armed)
  );

  eth_filt_hdr #(.HLEN(HDR_LEN), .DLEN(DA_LEN), .TPOS(TYPE_POS)) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_sof(rx_sof), .in_data(rx_data),
    .da(da), .type_hi(type_hi), .last_byte(last_byte), .sof_take(sof_take)
  );

  // The last header byte is the low type octet; use it straight from the stream.
  eth_filt_match #(.NA(NA), .NT(NT), .IW(IW)) u_match (
    .frm_addr(frm_addr), .frm_type(frm_type),
    .da(da), .ftype({type_hi, rx_data}),
    .a_hit(m_ahit), .t_hit(m_thit), .t_idx(m_tidx), .is_mc(m_mc), .is_bc(m_bc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      addr_hit  <= '0;
      type_hit  <= 1'b0;
      type_idx  <= '0;
      mcast     <= 1'b0;
      bcast     <= 1'b0;
    end else if (sof_take) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      addr_hit  <= '0;
      type_hit  <= 1'b0;
      type_idx  <= '0;
      mcast     <= 1'b0;
      bcast     <= 1'b0;
    end else if (last_byte) begin
      res_valid <= 1'b1;
      accept    <= (|m_ahit) | m_thit;
      addr_hit  <= m_ahit;
      type_hit  <= m_thit;
      type_idx  <= m_tidx;
      mcast     <= m_mc;
      bcast     <= m_bc;
    end else begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter_chk.sv
module eth_rx_addr_filter_chk #(
  parameter int NA = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_sof,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic          res_valid,
  input logic          accept,
  input logic [NA-1:0] addr_hit,
  input logic          type_hit,
  input logic [IW-1:0] type_idx,
  input logic          mcast,
  input logic          bcast,
  input logic [NA-1:0] live_armed
);
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |=> (!res_valid && !accept && addr_hit == '0 && !type_hit)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !$past(rx_valid && rx_sof)) |->
      ($stable(accept) && $stable(addr_hit) && $stable(type_hit) && $stable(type_idx))); // R9
  AST_ACCEPT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((|addr_hit) || type_hit)); // R8
  AST_HIT_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ((|addr_hit) || type_hit)) |-> accept); // R8
  AST_BCAST_IS_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
    bcast |-> mcast); // R10
  AST_IDX_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !type_hit |-> (type_idx == '0)); // R7
  AST_LO_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[3:2] == 2'd0) |=> !live_armed[$past(reg_addr[1:0])]); // R4
  AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[3:2] == 2'd1) |=> live_armed[$past(reg_addr[1:0])]); // R4
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk #(.NA(NA), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .reg_we(reg_we), .reg_addr(reg_addr), .res_valid(res_valid), .accept(accept),
  .addr_hit(addr_hit), .type_hit(type_hit), .type_idx(type_idx),
  .mcast(mcast), .bcast(bcast), .live_armed(live_armed)
);

// File: tb/eth_rx_addr_filter_tb.sv
module eth_rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic        res_valid, accept, type_hit, mcast, bcast;
  logic [3:0]  addr_hit;
  logic [1:0]  type_idx;

  int errs = 0;
  int nchk = 0;
  int cyc = 0;

  logic [31:0] m_lo [4];
  logic [15:0] m_hi [4];
  logic        m_arm [4];
  logic [31:0] m_typ [4];

  logic [3:0] e_ahit;
  logic       e_thit, e_acc, e_mc, e_bc;
  logic [1:0] e_tidx;

  always #5 clk = ~clk;

  eth_rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_data(rx_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .res_valid(res_valid), .accept(accept),
    .addr_hit(addr_hit), .type_hit(type_hit), .type_idx(type_idx),
    .mcast(mcast), .bcast(bcast)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; nchk++;
      $display("FAIL watchdog: run did not finish actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_arm[i] = 1'b0; m_typ[i] = '0;
    end
  endfunction

  function automatic void model_wr(input logic [3:0] a, input logic [31:0] d);
    case (a[3:2])
      2'd0: begin m_lo[a[1:0]] = d; m_arm[a[1:0]] = 1'b0; end
      2'd1: begin m_hi[a[1:0]] = d[15:0]; m_arm[a[1:0]] = 1'b1; end
      2'd2: m_typ[a[1:0]] = d;
      default: ;
    endcase
  endfunction

  function automatic void predict(input logic [47:0] da, input logic [15:0] ty);
    e_thit = 1'b0; e_tidx = 2'd0;
    for (int i = 0; i < 4; i++)
      e_ahit[i] = m_arm[i] && (da == {m_hi[i], m_lo[i]});
    for (int j = 3; j >= 0; j--)
      if (m_typ[j][31] && m_typ[j][15:0] == ty) begin e_thit = 1'b1; e_tidx = 2'(j); end
    e_acc = (|e_ahit) | e_thit;
    e_mc  = da[0];
    e_bc  = &da;
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic run_frame(input logic [47:0] da, input logic [15:0] ty, input int extra,
                           input bit gaps, input bit midwr, input logic [3:0] wa,
                           input logic [31:0] wd);
    logic [7:0] b [14];
    predict(da, ty);
    for (int k = 0; k < 14; k++) b[k] = 8'($urandom);
    for (int k = 0; k < 6; k++) b[k] = da[8*k +: 8];
    b[12] = ty[15:8];
    b[13] = ty[7:0];
    for (int k = 0; k < 14 + extra; k++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        reg_we = 1'b0; rx_valid = 1'b0; rx_sof = 1'b1; rx_data = 8'($urandom);
      end
      @(negedge clk);
      reg_we = 1'b0;
      rx_valid = 1'b1;
      rx_sof = (k == 0);
      rx_data = (k < 14) ? b[k] : 8'($urandom);
      if (midwr && k == 6) begin
        reg_we = 1'b1; reg_addr = wa; reg_wdata = wd;
      end
      @(posedge clk);
      #1;
      if (midwr && k == 6) model_wr(wa, wd);
      if (k == 0)
        chk(!res_valid && !accept && addr_hit == 0 && !type_hit, "R9", "sof clears result",
            {res_valid, accept, addr_hit, type_hit}, 0);
      else if (k == 13) begin
        chk(res_valid, "R9", "strobe after byte 13", res_valid, 1);
        chk(addr_hit == e_ahit, "R5", "addr_hit", addr_hit, e_ahit);
        chk(type_hit == e_thit && type_idx == e_tidx, "R7", "type hit/idx",
            {type_hit, type_idx}, {e_thit, e_tidx});
        chk(accept == e_acc, "R8", "accept", accept, e_acc);
        chk(mcast == e_mc && bcast == e_bc, "R10", "mcast/bcast",
            {mcast, bcast}, {e_mc, e_bc});
      end else if (res_valid) begin
        chk(1'b0, "R9", "stray strobe", res_valid, 0);
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(!res_valid && accept == e_acc && addr_hit == e_ahit, "R9", "result held",
        {res_valid, accept, addr_hit}, {1'b0, e_acc, e_ahit});
  endtask

  localparam logic [47:0] DA_EX = 48'hCBA9_8765_4321;

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready && !res_valid && !accept && addr_hit == 0 && !type_hit && type_idx == 0
        && !mcast && !bcast, "R12", "reset outputs", {rx_ready, res_valid, accept, addr_hit},
        {1'b1, 6'h0});

    // R1: bytes before any start of frame give no result; ready stays high
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'($urandom);
        @(posedge clk); #1;
        if (res_valid || !rx_ready) seen = 1'b1;
      end
      @(negedge clk); rx_valid = 1'b0;
      chk(!seen, "R1", "no result without sof", seen, 0);
    end

    // R3 R2: example address in slot 1
    reg_write(4'h1, 32'h8765_4321);
    reg_write(4'h5, 32'h0000_CBA9);
    run_frame(DA_EX, 16'h4321, 0, 0, 0, 4'h0, 0);
    chk(addr_hit == 4'b0010, "R3", "example address hits slot 1", addr_hit, 4'b0010);

    // R6: enable bit and ignored upper bits
    reg_write(4'h8, 32'h0000_4321);
    reg_write(4'hA, 32'h8ABC_4321);
    run_frame(48'h0000_0000_1234, 16'h4321, 2, 0, 0, 4'h0, 0);
    chk(type_hit && type_idx == 2'd2, "R6", "enabled slot 2 with junk bits", {type_hit, type_idx}, 3'b110);

    // R7: contention, lowest wins
    reg_write(4'hB, 32'h8000_4321);
    run_frame(48'h0000_0000_1234, 16'h4321, 0, 1, 0, 4'h0, 0);
    reg_write(4'h8, 32'h8001_4321);
    run_frame(48'h0000_0000_1234, 16'h4321, 0, 0, 0, 4'h0, 0);
    chk(type_idx == 2'd0, "R7", "lowest index wins", type_idx, 0);

    // R4: lower write disarms; type mismatch so accept drops
    reg_write(4'h1, 32'h8765_4321);
    run_frame(DA_EX, 16'h0800, 0, 0, 0, 4'h0, 0);
    chk(!accept && addr_hit == 0, "R4", "disarmed slot no hit", {accept, addr_hit}, 0);

    // R10: broadcast and unicast
    run_frame(48'hFFFF_FFFF_FFFF, 16'h0806, 1, 0, 0, 4'h0, 0);
    run_frame(48'h0102_0304_0500, 16'h0806, 0, 1, 0, 4'h0, 0);

    // R11: mid-frame disarm does not change current frame
    reg_write(4'h0, 32'h1122_3344);
    reg_write(4'h4, 32'h0000_5566);
    run_frame(48'h5566_1122_3344, 16'h0000, 0, 0, 1, 4'h0, 32'h1122_3344);
    chk(addr_hit[0], "R11", "mid-frame write deferred", addr_hit, 1);
    run_frame(48'h5566_1122_3344, 16'h0000, 0, 0, 0, 4'h0, 0);
    chk(!addr_hit[0], "R11", "write applies to next frame", addr_hit, 0);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [47:0] da;
      logic [15:0] ty;
      int s;
      if ($urandom % 3 == 0) reg_write(4'($urandom % 12), $urandom);
      if ($urandom % 4 == 0) reg_write(4'(4 + $urandom % 4), $urandom);
      s = $urandom % 4;
      da = ($urandom % 2) ? {m_hi[s], m_lo[s]} : {16'($urandom), 32'($urandom)};
      ty = ($urandom % 2) ? m_typ[$urandom % 4][15:0] : 16'($urandom);
      run_frame(da, ty, $urandom % 5, 1, ($urandom % 5 == 0), 4'($urandom % 12), $urandom);
    end

    // R12: reset disarms slots and disables types
    reg_write(4'h2, 32'hDEAD_BEEF);
    reg_write(4'h6, 32'h0000_0A0B);
    reg_write(4'h9, 32'h8000_88B5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    run_frame(48'h0A0B_DEAD_BEEF, 16'h88B5, 0, 0, 0, 4'h0, 0);
    chk(!accept, "R12", "slots cleared by reset", accept, 0);

    summary();
    $finish;
  end
endmodule